// File: doc/BRIEF.md
# Asynchronous Display Bus Strobe Generator

This block runs read and write cycles on an asynchronous parallel bus that connects to a display controller. Everything is clocked by one fast system clock. Each access type has its own programmable length. Each type also has its own programmable strobe-low window. For reads there is a separate programmable point at which the incoming data is sampled. The strobe edges can fall on either clock edge, so they are placed to a resolution of half a system clock.

The host offers one access at a time through a valid/ready handshake. Each request carries a direction, a command/data flag and the write data. The timing values are taken from the configuration ports at the moment the access is accepted, after clamping. They then stay frozen until that access ends. For the whole access the block drives the following:

- an active-low chip select
- the direction line
- the command/data line
- the active-low strobe
- the write data and its output enable

When the access ends, the block raises a one-cycle done pulse together with the read data it captured.

Top module: `dbus_strobe_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select is high, the strobe is high, ready is high, done is low and the output enable is low.
- R2: An access is accepted at a rising clock edge where valid and ready are both high. Ready stays low from that edge until the access ends. At least one idle cycle, with chip select high, separates two accesses.
- R3: Chip select goes low for exactly P system clocks after the accept edge. P is the period setting of the chosen direction, and a setting of 0 is taken as 1.
- R4: The direction line (1 = read, 0 = write) and the command line (copy of the request's command flag) change only at the accept edge. They hold their values through the whole access.
- R5: Half-clock index h counts from 0 at the accept edge. The strobe is low exactly for down <= h < up, using the read settings for reads and the write settings for writes.
- R6: An odd edge setting places that strobe edge on the falling clock edge halfway through a system clock.
- R7: An edge setting of 0, or one larger than 2P, is taken as 2P. A down setting of 0 therefore gives no strobe pulse, and a large up setting keeps the strobe low until the access ends.
- R8: For a write, the data lines carry the request's write data and the output enable is high for all P clocks. For a read, the output enable stays low.
- R9: For a read, the data input is captured at the rising edge S clocks after the accept edge. A sample setting of 0, or one larger than P, is taken as P.
- R10: The done output is high for exactly one cycle, starting at the edge where the access ends. The captured read data is presented on the read-data output alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both edges are used for the strobe |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_period | input | PER_W | Read access length in clocks |
| cfg_rd_down | input | PER_W+1 | Read strobe fall point in half clocks |
| cfg_rd_up | input | PER_W+1 | Read strobe rise point in half clocks |
| cfg_rd_sample | input | PER_W | Read data sampling point in clocks |
| cfg_wr_period | input | PER_W | Write access length in clocks |
| cfg_wr_down | input | PER_W+1 | Write strobe fall point in half clocks |
| cfg_wr_up | input | PER_W+1 | Write strobe rise point in half clocks |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 1 | Command/data flag driven onto the bus |
| req_wdata | input | DATA_W | Write data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_nwr | output | 1 | Direction line, 1 = read |
| bus_cmd | output | 1 | Command/data line |
| bus_strobe_n | output | 1 | Active-low interface strobe |
| bus_dout | output | DATA_W | Data driven to the display |
| bus_oe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data returned by the display |
| done_valid | output | 1 | One-cycle end-of-access pulse |
| done_rdata | output | DATA_W | Captured read data |

## Verification
The assertions rely on a few assumptions about the inputs:

- The request fields and the configuration ports are read only at the accept edge.
- The clock's two phases are long enough for the strobe's AND gate to settle.
- bus_din is settled before the capturing rising edge.

The stimulus changes configuration and request fields only one nanosecond after a rising edge, and only while the block is idle. It drives a new data-input value each cycle, shortly after the rising edge. Each captured value therefore names the cycle it came from.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  localparam int PER_W  = 8;          // width of clock-count settings
  localparam int HALF_W = PER_W + 1;  // width of half-clock settings

  typedef struct packed {
    logic              write;
    logic [PER_W-1:0]  period;
    logic [PER_W-1:0]  sample;
    logic [HALF_W-1:0] down;
    logic [HALF_W-1:0] up;
  } timing_t;
endpackage

// File: rtl/dbus_timing_sel.sv
module dbus_timing_sel
  import dbus_pkg::*;
(
  input  logic              is_write,
  input  logic [PER_W-1:0]  rd_period,
  input  logic [HALF_W-1:0] rd_down,
  input  logic [HALF_W-1:0] rd_up,
  input  logic [PER_W-1:0]  rd_sample,
  input  logic [PER_W-1:0]  wr_period,
  input  logic [HALF_W-1:0] wr_down,
  input  logic [HALF_W-1:0] wr_up,
  output timing_t           tim
);
  localparam logic [PER_W-1:0] ONE_P = PER_W'(1);

  logic [PER_W-1:0]  per_raw, per_eff;
  logic [HALF_W-1:0] per_half, dn_raw, up_raw;

  always_comb begin
    per_raw  = is_write ? wr_period : rd_period;
    dn_raw   = is_write ? wr_down   : rd_down;
    up_raw   = is_write ? wr_up     : rd_up;
    per_eff  = (per_raw == '0) ? ONE_P : per_raw;
    per_half = {per_eff, 1'b0};

    tim.write  = is_write;
    tim.period = per_eff;
    tim.down   = (dn_raw == '0 || dn_raw > per_half) ? per_half : dn_raw;
    tim.up     = (up_raw == '0 || up_raw > per_half) ? per_half : up_raw;
    tim.sample = (is_write || rd_sample == '0 || rd_sample > per_eff) ? per_eff : rd_sample;
  end
endmodule

// File: rtl/dbus_access_seq.sv
module dbus_access_seq
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_cmd,
  input  logic [DATA_W-1:0] req_wdata,
  input  timing_t           sel_tim,
  input  logic [DATA_W-1:0] bus_din,
  output logic              busy,
  output logic [PER_W-1:0]  cnt,
  output timing_t           tim_q,
  output logic              nxt_busy,
  output logic [PER_W-1:0]  nxt_cnt,
  output timing_t           nxt_tim,
  output logic              cs_n,
  output logic              rd_nwr,
  output logic              cmd,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [PER_W-1:0] ONE_P = PER_W'(1);

  logic start, finish, grab;

  always_comb begin
    nxt_busy = busy;
    nxt_cnt  = cnt;
    nxt_tim  = tim_q;
    start    = 1'b0;
    finish   = 1'b0;
    if (!busy) begin
      if (req_valid) begin
        start    = 1'b1;
        nxt_busy = 1'b1;
        nxt_cnt  = '0;
        nxt_tim  = sel_tim;
      end
    end else if (cnt == tim_q.period - ONE_P) begin
      finish   = 1'b1;
      nxt_busy = 1'b0;
    end else begin
      nxt_cnt = cnt + ONE_P;
    end
  end

  assign grab = busy && !tim_q.write && (cnt == tim_q.sample - ONE_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      tim_q  <= '0;
      cs_n   <= 1'b1;
      rd_nwr <= 1'b1;
      cmd    <= 1'b0;
      dout   <= '0;
      oe     <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      busy  <= nxt_busy;
      cnt   <= nxt_cnt;
      tim_q <= nxt_tim;
      done  <= finish;
      if (grab) rdata <= bus_din;
      if (start) begin
        cs_n   <= 1'b0;
        rd_nwr <= !sel_tim.write;
        cmd    <= req_cmd;
        oe     <= sel_tim.write;
        if (sel_tim.write) dout <= req_wdata;
      end else if (finish) begin
        cs_n <= 1'b1;
        oe   <= 1'b0;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < tim_q.period)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

// File: rtl/dbus_strobe_gen.sv
module dbus_strobe_gen
  import dbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_act,
  input  logic [PER_W-1:0]  nxt_cnt,
  input  logic [HALF_W-1:0] nxt_down,
  input  logic [HALF_W-1:0] nxt_up,
  input  logic              cur_act,
  input  logic [PER_W-1:0]  cur_cnt,
  input  logic [HALF_W-1:0] cur_down,
  input  logic [HALF_W-1:0] cur_up,
  output logic              strobe_n
);
  localparam logic [HALF_W:0] ONE_H = (HALF_W+1)'(1);

  // Marks half-cycles in [down-1, up); the strobe is low where two
  // consecutive halves are marked, i.e. over [down, up).
  function automatic logic in_mark(input logic [PER_W-1:0] c, input logic odd,
                                   input logic [HALF_W-1:0] d, input logic [HALF_W-1:0] u);
    logic [HALF_W:0] h, h1;
    h  = {1'b0, c, odd};
    h1 = h + ONE_H;
    return (h1 >= {1'b0, d}) && (h < {1'b0, u});
  endfunction

  logic mark_p, mark_n;

  always_ff @(posedge clk) begin
    if (rst) mark_p <= 1'b0;
    else     mark_p <= nxt_act && in_mark(nxt_cnt, 1'b0, nxt_down, nxt_up);
  end

  always_ff @(negedge clk) begin
    if (rst) mark_n <= 1'b0;
    else     mark_n <= cur_act && in_mark(cur_cnt, 1'b1, cur_down, cur_up);
  end

  // Only one input of the gate changes at any clock edge: no glitch.
  assign strobe_n = ~(mark_p & mark_n);

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cur_act |-> strobe_n); // R5
endmodule

// File: rtl/dbus_strobe_ctrl.sv
module dbus_strobe_ctrl
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  cfg_rd_period,
  input  logic [HALF_W-1:0] cfg_rd_down,
  input  logic [HALF_W-1:0] cfg_rd_up,
  input  logic [PER_W-1:0]  cfg_rd_sample,
  input  logic [PER_W-1:0]  cfg_wr_period,
  input  logic [HALF_W-1:0] cfg_wr_down,
  input  logic [HALF_W-1:0] cfg_wr_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_cs_n,
  output logic              bus_rd_nwr,
  output logic              bus_cmd,
  output logic              bus_strobe_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              done_valid,
  output logic [DATA_W-1:0] done_rdata
);
  timing_t          sel_tim, tim_q, nxt_tim;
  logic             busy, nxt_busy;
  logic [PER_W-1:0] cnt, nxt_cnt;

  dbus_timing_sel u_sel (
    .is_write (req_write),
    .rd_period(cfg_rd_period),
    .rd_down  (cfg_rd_down),
    .rd_up    (cfg_rd_up),
    .rd_sample(cfg_rd_sample),
    .wr_period(cfg_wr_period),
    .wr_down  (cfg_wr_down),
    .wr_up    (cfg_wr_up),
    .tim      (sel_tim)
  );

  dbus_access_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_cmd  (req_cmd),
    .req_wdata(req_wdata),
    .sel_tim  (sel_tim),
    .bus_din  (bus_din),
    .busy     (busy),
    .cnt      (cnt),
    .tim_q    (tim_q),
    .nxt_busy (nxt_busy),
    .nxt_cnt  (nxt_cnt),
    .nxt_tim  (nxt_tim),
    .cs_n     (bus_cs_n),
    .rd_nwr   (bus_rd_nwr),
    .cmd      (bus_cmd),
    .dout     (bus_dout),
    .oe       (bus_oe),
    .done     (done_valid),
    .rdata    (done_rdata)
  );

  dbus_strobe_gen u_stb (
    .clk     (clk),
    .rst     (rst),
    .nxt_act (nxt_busy),
    .nxt_cnt (nxt_cnt),
    .nxt_down(nxt_tim.down),
    .nxt_up  (nxt_tim.up),
    .cur_act (busy),
    .cur_cnt (cnt),
    .cur_down(tim_q.down),
    .cur_up  (tim_q.up),
    .strobe_n(bus_strobe_n)
  );

  assign req_ready = !busy;

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_cs_n); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_rd_nwr) && $stable(bus_cmd))); // R4
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_dout)); // R8
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!bus_cs_n && !bus_rd_nwr)); // R8
endmodule

// File: tb/dbus_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbus_strobe_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_rd_period = '0, cfg_rd_sample = '0, cfg_wr_period = '0;
  logic [8:0]  cfg_rd_down = '0, cfg_rd_up = '0, cfg_wr_down = '0, cfg_wr_up = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cmd = 1'b0;
  logic [15:0] req_wdata = '0, bus_din = '0;
  logic        req_ready, bus_cs_n, bus_rd_nwr, bus_cmd, bus_strobe_n, bus_oe, done_valid;
  logic [15:0] bus_dout, done_rdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  dbus_strobe_ctrl #(.DATA_W(16)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_rd_period(cfg_rd_period), .cfg_rd_down(cfg_rd_down), .cfg_rd_up(cfg_rd_up),
    .cfg_rd_sample(cfg_rd_sample), .cfg_wr_period(cfg_wr_period),
    .cfg_wr_down(cfg_wr_down), .cfg_wr_up(cfg_wr_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cmd(req_cmd), .req_wdata(req_wdata),
    .bus_cs_n(bus_cs_n), .bus_rd_nwr(bus_rd_nwr), .bus_cmd(bus_cmd),
    .bus_strobe_n(bus_strobe_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .done_valid(done_valid), .done_rdata(done_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // One half-clock sample; h counts from the accept edge.
  task automatic check_half(input int h, input bit wr, input bit cmd, input logic [15:0] wd,
                            input int pe, input int de, input int ue, input int se,
                            input string etag);
    bit act = (h < 2*pe);
    bit low = act && (h >= de) && (h < ue);
    chk((h % 2 == 1) ? "R6 strobe odd half" : {etag, " strobe"}, bus_strobe_n, !low);
    chk("R3 chip select", bus_cs_n, !act);
    chk("R2 ready", req_ready, !act);
    if (act) begin
      chk("R4 direction", bus_rd_nwr, !wr);
      chk("R4 command", bus_cmd, cmd);
      chk("R8 output enable", bus_oe, wr);
      if (wr) chk("R8 write data", bus_dout, wd);
    end
    chk("R10 done", done_valid, !act);
    if (!act && !wr) chk("R9 read data", done_rdata, 16'hA500 + se - 1);
  endtask

  // Raw settings go to the ports; pe/de/ue/se are the expected clamped values.
  task automatic do_access(input bit wr, input bit cmd, input logic [15:0] wd,
                           input int p, input int d, input int u, input int s,
                           input int pe, input int de, input int ue, input int se,
                           input bit hold, input string etag);
    if (wr) begin
      cfg_wr_period = p[7:0]; cfg_wr_down = d[8:0]; cfg_wr_up = u[8:0];
    end else begin
      cfg_rd_period = p[7:0]; cfg_rd_down = d[8:0]; cfg_rd_up = u[8:0]; cfg_rd_sample = s[7:0];
    end
    req_write = wr; req_cmd = cmd; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1;
    if (!hold) req_valid = 1'b0;
    req_wdata = ~wd;  // later changes must not reach the bus (R8)
    for (int k = 0; k <= pe; k++) begin
      bus_din = 16'hA500 + 16'(k);
      check_half(2*k, wr, cmd, wd, pe, de, ue, se, etag);
      #2;
      check_half(2*k+1, wr, cmd, wd, pe, de, ue, se, etag);
      #2;
    end
    chk("R10 done one cycle", done_valid, 0);
    if (hold) begin
      chk("R2 second access after idle gap", bus_cs_n, 0);
      req_valid = 1'b0;
      repeat (pe + 2) @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    chk("R1 cs_n", bus_cs_n, 1);
    chk("R1 strobe", bus_strobe_n, 1);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done_valid, 0);
    chk("R1 oe", bus_oe, 0);
    #2;
    chk("R1 strobe low phase", bus_strobe_n, 1);
    #2;
  endtask

  task automatic t_write_basic;  // R5 R6 R8 R4
    do_access(1, 1, 16'h3C5A, 6, 3, 9, 0, 6, 3, 9, 6, 0, "R5");
  endtask

  task automatic t_read_basic;  // R5 R9 R10, write settings differ
    cfg_wr_down = 9'd1; cfg_wr_up = 9'd2;
    do_access(0, 0, 16'h0000, 5, 2, 7, 3, 5, 2, 7, 3, 0, "R5");
  endtask

  task automatic t_read_clamp_sample;  // R9 R7: sample 0 -> P
    do_access(0, 1, 16'h0000, 4, 4, 8, 0, 4, 4, 8, 4, 0, "R5");
  endtask

  task automatic t_edge_clamp;  // R7
    do_access(1, 0, 16'h1234, 3, 0, 4, 0, 3, 6, 4, 3, 0, "R7");
    do_access(1, 1, 16'hBEEF, 4, 1, 200, 0, 4, 1, 8, 4, 0, "R7");
    do_access(0, 0, 16'h0000, 3, 2, 0, 9, 3, 2, 6, 3, 0, "R7");
  endtask

  task automatic t_period_zero;  // R3: period 0 acts as 1
    do_access(0, 1, 16'h0000, 0, 1, 2, 1, 1, 1, 2, 1, 0, "R3");
  endtask

  task automatic t_back_to_back;  // R2
    do_access(1, 0, 16'h5A5A, 2, 1, 3, 0, 2, 1, 3, 2, 1, "R2");
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    @(posedge clk); #1;
    t_write_basic();
    t_read_basic();
    t_read_clamp_sample();
    t_edge_clamp();
    t_period_zero();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule